// File: doc/BRIEF.md
# Incremental-Step Page Program Sequencer

This block runs one page-program operation on a NAND array. At start it captures which bit-lines of the page must be programmed and, for the upper page of a two-bit cell, whether each one aims at the middle or the top threshold level. It then repeats a loop of one program pulse and one or more verify windows until no cell remains to be programmed. The program-voltage code begins at a start value and rises by a fixed step after every pulse. That start value is lower when the selected word-line is the first or last in the string.

Each bit-line has a small target register. A cell that passes verify has its target cleared. From then on it is inhibited: the next pulses skip it, and it is not precharged in later verify windows. Within one loop the verify windows visit the levels from low to high. A level that no pending cell targets gets no window. The operation ends with `done` once every target is cleared, or with `fail` once a set number of pulses has been spent. The testbench models the cells; the pumps and the sense amplifiers are not part of the block.

Top module: `ispp_seq`

## Requirements
- R1: After a synchronous reset, busy, done, fail, pgm_pulse and vfy_strobe are low, bl_pgm and pre_en are all zero, vfy_level is 0 and vcode is 0.
- R2: The clock edge that accepts start loads vcode with VSTART, or with VEDGE when edge_wl is high. The same edge captures the targets. With page_hi low, want[i]=1 targets level A (code 1). With page_hi high, want[i]=1 targets B (code 2) when to_c[i]=0 and C (code 3) when to_c[i]=1. want[i]=0 means nothing to program.
- R3: After the last cycle of each pulse, vcode rises by VSTEP, capped at VMAX. At all other times vcode holds its value.
- R4: Each loop is one check cycle, then a pulse of TP cycles with pgm_pulse high, then verify windows of TV cycles each with vfy_strobe high.
- R5: During a pulse, bl_pgm[i] is high exactly for the bit-lines whose target is still pending. bl_pgm is zero outside pulses.
- R6: vfy_level gives the level under verify (1=A, 2=B, 3=C) and is 0 outside verify. Windows run in rising level order. A level with no pending cell is skipped.
- R7: pre_en[i] is high only during verify, and only for bit-lines whose pending target equals the level under verify.
- R8: On the last cycle of a window, a bit-line with pre_en high and sense high has its target cleared. sense on a bit-line without pre_en has no effect.
- R9: When the check cycle finds no pending target, the operation ends with done high and busy low. This includes a start with no targets, which ends after zero pulses.
- R10: When the check cycle finds targets still pending after MAXP pulses, the operation ends with fail high and done low.
- R11: start is ignored while busy. A new accepted start clears done and fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| page_hi | input | 1 | 0: lower page (level A); 1: upper page (levels B/C) |
| edge_wl | input | 1 | Selected word-line is at a string edge |
| want | input | NBL | Bit-lines to program |
| to_c | input | NBL | Upper page: target C instead of B |
| sense | input | NBL | Verify result per bit-line (1 = above level) |
| vcode | output | VW | Program-voltage code |
| pgm_pulse | output | 1 | Program pulse strobe |
| bl_pgm | output | NBL | Per-bit-line program enable during the pulse |
| vfy_strobe | output | 1 | Verify window strobe |
| vfy_level | output | 2 | Level under verify (1=A, 2=B, 3=C) |
| pre_en | output | NBL | Per-bit-line precharge enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Page passed |
| fail | output | 1 | Pulse limit reached |

## Verification
Assertions checked on every cycle cover these rules: precharge happens only in verify and program enable only in a pulse, the two never overlap, vcode never falls during an operation, a cleared target never comes back without a new load, the pulse count stays at or below the limit, and done and fail are never high together. The bench scenarios are needed for the rest: the exact step and cap values, level ordering and skipping (a level whose cells all finished early gets no further windows), and sense being ignored on bit-lines without precharge (the bench forces sense high there). They also show the zero-pulse completion, the failure at the pulse limit, and the rejection of a start that arrives mid-operation.

// File: rtl/ispp_pkg.sv
package ispp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_PULSE = 2'd2,
    ST_VFY   = 2'd3
  } ispp_state_t;

  localparam logic [1:0] LV_NONE = 2'd0;
  localparam logic [1:0] LV_A    = 2'd1;
  localparam logic [1:0] LV_B    = 2'd2;
  localparam logic [1:0] LV_C    = 2'd3;
endpackage

// File: rtl/ispp_latches.sv
module ispp_latches
  import ispp_pkg::*;
#(
  parameter int NBL = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           page_hi,
  input  logic [NBL-1:0] want,
  input  logic [NBL-1:0] to_c,
  input  logic           pulse,
  input  logic           vfy,
  input  logic [1:0]     lvl,
  input  logic           commit,
  input  logic [NBL-1:0] sense,
  output logic [NBL-1:0] bl_pgm,
  output logic [NBL-1:0] pre_en,
  output logic           any_a,
  output logic           any_b,
  output logic           any_c
);
  logic [NBL-1:0] pend;
  logic [NBL-1:0] hit_a, hit_b, hit_c;

  for (genvar i = 0; i < NBL; i++) begin : g_bl
    logic [1:0] tgt;

    always_ff @(posedge clk) begin
      if (rst) begin
        tgt <= LV_NONE;
      end else if (load) begin
        if (!want[i])      tgt <= LV_NONE;
        else if (!page_hi) tgt <= LV_A;
        else if (to_c[i])  tgt <= LV_C;
        else               tgt <= LV_B;
      end else if (commit && (tgt == lvl) && sense[i]) begin
        tgt <= LV_NONE;
      end
    end

    assign pend[i]   = (tgt != LV_NONE);
    assign hit_a[i]  = (tgt == LV_A);
    assign hit_b[i]  = (tgt == LV_B);
    assign hit_c[i]  = (tgt == LV_C);
    assign bl_pgm[i] = pulse & pend[i];
    assign pre_en[i] = vfy & (tgt == lvl) & pend[i];
  end

  assign any_a = |hit_a;
  assign any_b = |hit_b;
  assign any_c = |hit_c;

  // R8
  no_revive_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((pend & ~$past(pend)) == '0));

  // R7
  pre_pgm_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((|pre_en) && (|bl_pgm)));
endmodule

// File: rtl/ispp_vgen.sv
module ispp_vgen #(
  parameter int VW     = 8,
  parameter int VSTART = 40,
  parameter int VEDGE  = 32,
  parameter int VSTEP  = 4,
  parameter int VMAX   = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          edge_wl,
  input  logic          step,
  output logic [VW-1:0] vcode
);
  localparam logic [VW:0]   CAP_W  = (VW+1)'(VMAX);
  localparam logic [VW:0]   STEP_W = (VW+1)'(VSTEP);
  localparam logic [VW-1:0] INIT_N = VW'(VSTART);
  localparam logic [VW-1:0] INIT_E = VW'(VEDGE);

  logic [VW:0]   sum;
  logic [VW-1:0] nxt;

  always_comb begin
    sum = {1'b0, vcode} + STEP_W;
    nxt = (sum > CAP_W) ? CAP_W[VW-1:0] : sum[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       vcode <= '0;
    else if (load) vcode <= edge_wl ? INIT_E : INIT_N;
    else if (step) vcode <= nxt;
  end

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(vcode));
endmodule

// File: rtl/ispp_fsm.sv
module ispp_fsm
  import ispp_pkg::*;
#(
  parameter int TP   = 3,
  parameter int TV   = 2,
  parameter int MAXP = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       any_a,
  input  logic       any_b,
  input  logic       any_c,
  output logic       load,
  output logic       step,
  output logic       pulse,
  output logic       vfy,
  output logic [1:0] lvl,
  output logic       commit,
  output logic       busy,
  output logic       done,
  output logic       fail
);
  localparam int TMAX = (TP > TV) ? TP : TV;
  localparam int TW   = $clog2(TMAX) + 1;
  localparam int CW   = $clog2(MAXP + 1);

  ispp_state_t   st;
  logic [TW-1:0] tmr;
  logic [CW-1:0] npulse;
  logic          none_left;
  logic [1:0]    first_lvl;

  assign none_left = !(any_a || any_b || any_c);
  assign first_lvl = any_a ? LV_A : (any_b ? LV_B : LV_C);

  assign load   = (st == ST_IDLE) && start;
  assign pulse  = (st == ST_PULSE);
  assign vfy    = (st == ST_VFY);
  assign step   = pulse && (tmr == '0);
  assign commit = vfy && (tmr == '0);
  assign busy   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      npulse <= '0;
      lvl    <= LV_NONE;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_CHECK;
          npulse <= '0;
          done   <= 1'b0;
          fail   <= 1'b0;
        end
        ST_CHECK: begin
          if (none_left) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else if (npulse == CW'(MAXP)) begin
            st   <= ST_IDLE;
            fail <= 1'b1;
          end else begin
            st  <= ST_PULSE;
            tmr <= TW'(TP - 1);
          end
        end
        ST_PULSE: begin
          if (tmr == '0) begin
            st     <= ST_VFY;
            npulse <= npulse + 1'b1;
            lvl    <= first_lvl;
            tmr    <= TW'(TV - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_VFY: begin
          if (tmr == '0) begin
            if (lvl == LV_A && any_b) begin
              lvl <= LV_B;
              tmr <= TW'(TV - 1);
            end else if (lvl != LV_C && any_c) begin
              lvl <= LV_C;
              tmr <= TW'(TV - 1);
            end else begin
              st <= ST_CHECK;
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    npulse <= CW'(MAXP));

  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  // R6
  lvl_valid_chk: assert property (@(posedge clk) disable iff (rst)
    vfy |-> (lvl != LV_NONE));
endmodule

// File: rtl/ispp_seq.sv
module ispp_seq
  import ispp_pkg::*;
#(
  parameter int NBL    = 16,
  parameter int VW     = 8,
  parameter int VSTART = 40,
  parameter int VEDGE  = 32,
  parameter int VSTEP  = 4,
  parameter int VMAX   = 255,
  parameter int TP     = 3,
  parameter int TV     = 2,
  parameter int MAXP   = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           page_hi,
  input  logic           edge_wl,
  input  logic [NBL-1:0] want,
  input  logic [NBL-1:0] to_c,
  input  logic [NBL-1:0] sense,
  output logic [VW-1:0]  vcode,
  output logic           pgm_pulse,
  output logic [NBL-1:0] bl_pgm,
  output logic           vfy_strobe,
  output logic [1:0]     vfy_level,
  output logic [NBL-1:0] pre_en,
  output logic           busy,
  output logic           done,
  output logic           fail
);
  logic       load, step, pulse, vfy, commit;
  logic       any_a, any_b, any_c;
  logic [1:0] lvl;

  ispp_fsm #(.TP(TP), .TV(TV), .MAXP(MAXP)) u_fsm (
    .clk(clk), .rst(rst), .start(start),
    .any_a(any_a), .any_b(any_b), .any_c(any_c),
    .load(load), .step(step), .pulse(pulse), .vfy(vfy), .lvl(lvl),
    .commit(commit), .busy(busy), .done(done), .fail(fail)
  );

  ispp_latches #(.NBL(NBL)) u_lat (
    .clk(clk), .rst(rst), .load(load), .page_hi(page_hi),
    .want(want), .to_c(to_c), .pulse(pulse), .vfy(vfy), .lvl(lvl),
    .commit(commit), .sense(sense), .bl_pgm(bl_pgm), .pre_en(pre_en),
    .any_a(any_a), .any_b(any_b), .any_c(any_c)
  );

  ispp_vgen #(.VW(VW), .VSTART(VSTART), .VEDGE(VEDGE), .VSTEP(VSTEP),
              .VMAX(VMAX)) u_vgen (
    .clk(clk), .rst(rst), .load(load), .edge_wl(edge_wl), .step(step),
    .vcode(vcode)
  );

  assign pgm_pulse  = pulse;
  assign vfy_strobe = vfy;
  assign vfy_level  = vfy ? lvl : LV_NONE;

  // R7
  pre_in_vfy_chk: assert property (@(posedge clk) disable iff (rst)
    (|pre_en) |-> vfy_strobe);

  // R5
  pgm_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (|bl_pgm) |-> pgm_pulse);

  // R3
  vcode_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (vcode >= $past(vcode)));
endmodule

// File: tb/ispp_seq_test.sv
module ispp_seq_test;
  localparam int NBL = 8, VW = 8, VS = 40, VE = 32, ST = 4, VMX = 64;
  localparam int TP = 3, TV = 2, MP = 12;
  localparam int THR_A = 10, THR_B = 20, THR_C = 30;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, page_hi = 1'b0, edge_wl = 1'b0;
  logic [NBL-1:0] want = '0, to_c = '0, sense = '0;
  logic [VW-1:0] vcode;
  logic pgm_pulse, vfy_strobe, busy, done, fail;
  logic [NBL-1:0] bl_pgm, pre_en;
  logic [1:0] vfy_level;

  int errors = 0, checks = 0;
  bit finished = 0, force_sense = 0;
  int ms = 0, mt = 0, mv = 0, mcnt = 0, mlvl = 0;
  bit mdone = 0, mfail = 0;
  int mtgt[NBL], vth[NBL], spd[NBL];
  int npulses = 0, nlvl_b = 0, nlvl_c = 0;

  ispp_seq #(.NBL(NBL), .VW(VW), .VSTART(VS), .VEDGE(VE), .VSTEP(ST),
             .VMAX(VMX), .TP(TP), .TV(TV), .MAXP(MP)) uut (
    .clk(clk), .rst(rst), .start(start), .page_hi(page_hi), .edge_wl(edge_wl),
    .want(want), .to_c(to_c), .sense(sense), .vcode(vcode),
    .pgm_pulse(pgm_pulse), .bl_pgm(bl_pgm), .vfy_strobe(vfy_strobe),
    .vfy_level(vfy_level), .pre_en(pre_en), .busy(busy), .done(done),
    .fail(fail));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit any_lvl(int l);
    for (int i = 0; i < NBL; i++) if (mtgt[i] == l) return 1;
    return 0;
  endfunction

  function automatic int next_lvl(int from);
    for (int l = from + 1; l <= 3; l++) if (any_lvl(l)) return l;
    return 0;
  endfunction

  function automatic int thr(int l);
    return (l == 1) ? THR_A : (l == 2) ? THR_B : THR_C;
  endfunction

  // behavioural reference model of the requirements
  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mv = 0; mdone = 0; mfail = 0; mlvl = 0;
      for (int i = 0; i < NBL; i++) mtgt[i] = 0;
    end else begin
      case (ms)
        0: if (start) begin
          for (int i = 0; i < NBL; i++)
            mtgt[i] = !want[i] ? 0 : !page_hi ? 1 : to_c[i] ? 3 : 2;
          mv = edge_wl ? VE : VS; mcnt = 0; mdone = 0; mfail = 0; ms = 1;
        end
        1: begin
          if (next_lvl(0) == 0) begin ms = 0; mdone = 1; end
          else if (mcnt == MP) begin ms = 0; mfail = 1; end
          else begin ms = 2; mt = TP - 1; end
        end
        2: begin
          for (int i = 0; i < NBL; i++) if (mtgt[i] != 0) vth[i] += spd[i];
          if (mt == 0) begin
            mv = (mv + ST > VMX) ? VMX : mv + ST;
            mcnt++; mlvl = next_lvl(0); mt = TV - 1; ms = 3;
          end else mt--;
        end
        default: begin
          if (mt == 0) begin
            for (int i = 0; i < NBL; i++)
              if (mtgt[i] == mlvl && sense[i]) mtgt[i] = 0;
            if (next_lvl(mlvl) != 0) begin mlvl = next_lvl(mlvl); mt = TV - 1; end
            else ms = 1;
          end else mt--;
        end
      endcase
    end
  end

  // cell model drives sense between edges
  always @(negedge clk) begin
    for (int i = 0; i < NBL; i++)
      sense[i] <= (ms == 3) &&
                  ((vth[i] >= thr(mlvl)) || (force_sense && mtgt[i] != mlvl));
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [NBL-1:0] eb, ep;
      for (int i = 0; i < NBL; i++) begin
        eb[i] = (ms == 2) && (mtgt[i] != 0);
        ep[i] = (ms == 3) && (mtgt[i] == mlvl);
      end
      chk("R3 vcode", vcode, mv);
      chk("R4 pgm_pulse", pgm_pulse, ms == 2);
      chk("R4 vfy_strobe", vfy_strobe, ms == 3);
      chk("R5 bl_pgm", bl_pgm, eb);
      chk("R6 vfy_level", vfy_level, (ms == 3) ? mlvl : 0);
      chk("R7 pre_en", pre_en, ep);
      chk("R9 busy", busy, ms != 0);
      chk("R9 done", done, mdone);
      chk("R10 fail", fail, mfail);
      if (pgm_pulse && mt == TP - 1) npulses++;
      if (vfy_level == 2) nlvl_b++;
      if (vfy_level == 3) nlvl_c++;
    end
  end

  task automatic run_op(input bit ph, input bit ew, input logic [NBL-1:0] w,
                        input logic [NBL-1:0] c, input int poke_at);
    npulses = 0; nlvl_b = 0; nlvl_c = 0;
    @(negedge clk);
    page_hi = ph; edge_wl = ew; want = w; to_c = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 start code", vcode, ew ? VE : VS);
    chk("R11 busy after start", busy, 1'b1);
    for (int k = 0; k < 2000 && busy; k++) begin
      @(negedge clk);
      if (k == poke_at) begin
        start = 1'b1; want = '0; page_hi = 1'b0;
        @(negedge clk);
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 vcode", vcode, 0);
    chk("R1 strobes", {pgm_pulse, vfy_strobe, vfy_level}, 0);
    chk("R1 vectors", {bl_pgm, pre_en}, 0);
    rst = 1'b0;

    // lower page, mixed speeds: slowest needs 4 pulses
    for (int i = 0; i < NBL; i++) begin vth[i] = 0; spd[i] = (i % 3 == 0) ? 1 : (i % 3 == 1) ? 2 : 4; end
    run_op(1'b0, 1'b0, 8'b1011_0111, '0, -1);
    chk("R9 done lower", done, 1);
    chk("R4 pulses lower", npulses, 4);
    chk("R3 vcode after 4 steps", vcode, VS + 4 * ST);

    // upper page, edge word-line, B fast, C slow, sense forced on idle lines
    force_sense = 1;
    for (int i = 0; i < NBL; i++) begin vth[i] = 12; spd[i] = (i < 4) ? 3 : 1; end
    run_op(1'b1, 1'b1, 8'b1111_1111, 8'b1111_0000, 5);
    force_sense = 0;
    chk("R8 C cells kept pending", npulses, 6);
    chk("R6 B window once", nlvl_b, TV);
    chk("R6 C windows", nlvl_c, 6 * TV);
    chk("R11 ignored start", {done, fail}, 2'b10);
    chk("R3 edge vcode end", vcode, VE + 6 * ST);

    // upper page, only C targets: B never verified
    for (int i = 0; i < NBL; i++) begin vth[i] = 12; spd[i] = 2; end
    run_op(1'b1, 1'b0, 8'b0000_1100, 8'b0000_1100, -1);
    chk("R6 B skipped", nlvl_b, 0);
    chk("R9 done C only", done, 1);

    // no targets
    run_op(1'b0, 1'b0, '0, '0, -1);
    chk("R9 zero pulses", npulses, 0);
    chk("R9 done empty", done, 1);

    // stuck cell -> fail at limit, code saturates
    for (int i = 0; i < NBL; i++) begin vth[i] = 0; spd[i] = (i == 2) ? 0 : 4; end
    run_op(1'b0, 1'b0, 8'b0000_0111, '0, -1);
    chk("R10 fail", {done, fail}, 2'b01);
    chk("R10 pulses at limit", npulses, MP);
    chk("R3 saturated", vcode, VMX);

    // new start clears fail
    for (int i = 0; i < NBL; i++) begin vth[i] = 0; spd[i] = 4; end
    run_op(1'b0, 1'b0, 8'b1000_0001, '0, -1);
    chk("R11 flags cleared", {done, fail}, 2'b10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule